// File: doc/BRIEF.md
# Fast Ethernet PCS Receive Decoder

This block turns an aligned stream of 5-bit received code-groups, one per clock, into the MII receive signals: a data-valid strobe, a 4-bit nibble and a receive-error flag. Outside a frame it watches for the start delimiter, a J group followed by a K group. It puts two preamble nibbles on the MII in place of that pair, then maps each data group back to its nibble until the end delimiter, T followed by R, closes the frame. Error and invalid groups inside a frame are flagged, and a J that is not followed by K is reported as a false carrier.

A frame may end with a few dribble bits that do not fill a whole nibble. The source of the code-groups reports them on two side inputs while it presents the T group: a count of trailing bits (0 means none) and the bits themselves. The decoder then emits at most one extra nibble in the T slot. Alignment, descrambling and clock recovery happen upstream.

Top module: `pcs_rx_decoder`

## Requirements
- R1: A J group (11000) followed at once by a K group (10001) outside a frame gives two output nibbles of 0101 with rxDv high and rxEr low, one for the J slot and one for the K slot.
- R2: Inside a frame each data group is decoded to its nibble with rxDv high and rxEr low, using this code-group-to-nibble map: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F.
- R3: A T group (01101) followed at once by an R group (00111) ends the frame. With no dribble bits, the T slot and the R slot both give rxDv low, rxEr low and rxd 0000, and the decoder again watches for the next start delimiter.
- R4: The result for a code-group sampled at one rising edge appears on the outputs after the next rising edge. The slot before a start delimiter still shows rxDv low.
- R5: With a trailing count of 1 to 4 presented alongside T, the T slot carries one nibble with rxDv high. Bit positions below the count come from the tail bits and the higher positions read 1.
- R6: With a trailing count of 5 to 7, the T slot carries the four lowest tail bits unchanged as one nibble with rxDv high. The remaining bits are dropped, so the R slot shows rxDv low.
- R7: An H group (00100) inside a frame gives rxDv high, rxEr high and rxd 0000 for that slot, and the frame continues.
- R8: Any other group that is not a data value inside a frame (for example 00000, I or K) gives rxDv high, rxEr high and rxd 0000.
- R9: A J outside a frame that is not followed by K gives a false carrier: rxDv low, rxEr high and rxd 1110 for that slot.
- R10: Idle (11111) outside a frame gives rxDv low, rxEr low and rxd 0000.
- R11: A T inside a frame that is not followed by R is treated as an invalid group (rxDv high, rxEr high), and the frame continues.
- R12: While reset is asserted, rxDv, rxEr and rxd are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one code-group per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| rxCode | input | 5 | Aligned received code-group |
| tailCount | input | 3 | Number of dribble bits at the end of the frame, valid with T (0 means none) |
| tailBits | input | 4 | The dribble bits, lowest position first received, valid with T |
| rxDv | output | 1 | MII receive data valid |
| rxd | output | 4 | MII receive nibble |
| rxEr | output | 1 | MII receive error |

## Verification
Each code-group's result is due exactly two rising edges after the bench drives it on a falling edge. It is sampled when the first group is captured, and the result becomes visible after the following edge, once the lookahead group is known. The bench keeps one expected entry per driven group. At each falling edge it compares the entry for the group driven two falling edges earlier, and only then drives the next group. Tail side inputs are driven in the same cycle as their T group, so the padded nibble is due in that T group's slot.

// File: rtl/pcsrx_pkg.sv
package pcsrx_pkg;

  localparam int GROUP_W = 5;
  localparam int NIB_W   = 4;
  localparam int TAIL_W  = 3;

  localparam logic [GROUP_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [GROUP_W-1:0] CG_J    = 5'b11000;
  localparam logic [GROUP_W-1:0] CG_K    = 5'b10001;
  localparam logic [GROUP_W-1:0] CG_T    = 5'b01101;
  localparam logic [GROUP_W-1:0] CG_R    = 5'b00111;

  localparam logic [NIB_W-1:0] PRE_NIB = 4'b0101;
  localparam logic [NIB_W-1:0] FC_NIB  = 4'b1110;

  typedef enum logic [1:0] {ST_IDLE, ST_SSD, ST_DATA, ST_END} rxState_t;

  typedef enum logic [2:0] {SEL_ZERO, SEL_PRE, SEL_DATA, SEL_TAIL, SEL_FC} rxdSel_t;

  typedef struct packed {
    logic    dv;
    logic    er;
    rxdSel_t sel;
  } strobe_t;

  typedef struct packed {
    logic holdJ;
    logic lookK;
    logic holdT;
    logic lookR;
    logic holdData;
    logic holdIdle;
    logic tailPend;
  } flags_t;

  // Returns {valid, nibble}; valid is low for every non-data group.
  function automatic logic [NIB_W:0] decodeGroup(input logic [GROUP_W-1:0] g);
    case (g)
      5'b11110: return {1'b1, 4'h0};
      5'b01001: return {1'b1, 4'h1};
      5'b10100: return {1'b1, 4'h2};
      5'b10101: return {1'b1, 4'h3};
      5'b01010: return {1'b1, 4'h4};
      5'b01011: return {1'b1, 4'h5};
      5'b01110: return {1'b1, 4'h6};
      5'b01111: return {1'b1, 4'h7};
      5'b10010: return {1'b1, 4'h8};
      5'b10011: return {1'b1, 4'h9};
      5'b10110: return {1'b1, 4'hA};
      5'b10111: return {1'b1, 4'hB};
      5'b11010: return {1'b1, 4'hC};
      5'b11011: return {1'b1, 4'hD};
      5'b11100: return {1'b1, 4'hE};
      5'b11101: return {1'b1, 4'hF};
      default:  return {1'b0, 4'h0};
    endcase
  endfunction

endpackage

// File: rtl/pcsrx_ctrl.sv
module pcsrx_ctrl
  import pcsrx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  flags_t   flags,
  output strobe_t  stb,
  output rxState_t state
);

  rxState_t stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '{dv: 1'b0, er: 1'b0, sel: SEL_ZERO};
    unique case (state)
      ST_IDLE: begin
        if (flags.holdJ && flags.lookK) begin
          stb       = '{dv: 1'b1, er: 1'b0, sel: SEL_PRE};
          stateNext = ST_SSD;
        end else if (flags.holdJ) begin
          stb = '{dv: 1'b0, er: 1'b1, sel: SEL_FC};
        end
      end
      ST_SSD: begin
        stb       = '{dv: 1'b1, er: 1'b0, sel: SEL_PRE};
        stateNext = ST_DATA;
      end
      ST_DATA: begin
        if (flags.holdT && flags.lookR) begin
          stateNext = ST_END;
          if (flags.tailPend) stb = '{dv: 1'b1, er: 1'b0, sel: SEL_TAIL};
        end else if (flags.holdData) begin
          stb = '{dv: 1'b1, er: 1'b0, sel: SEL_DATA};
        end else begin
          stb = '{dv: 1'b1, er: 1'b1, sel: SEL_ZERO};
        end
      end
      ST_END: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  AST_END_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_END) |=> (state == ST_IDLE)) else $error("end slot not followed by idle"); // R3

endmodule

// File: rtl/pcsrx_dp.sv
module pcsrx_dp
  import pcsrx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [GROUP_W-1:0] rxCode,
  input  logic [TAIL_W-1:0]  tailCount,
  input  logic [NIB_W-1:0]   tailBits,
  input  strobe_t            stb,
  output flags_t             flags,
  output logic               rxDv,
  output logic [NIB_W-1:0]   rxd,
  output logic               rxEr
);

  logic [GROUP_W-1:0] holdCode;
  logic [TAIL_W-1:0]  tailCntReg;
  logic [NIB_W-1:0]   tailBitsReg;
  logic               holdValid;
  logic [NIB_W-1:0]   holdNib;
  logic [NIB_W-1:0]   tailNib;
  logic [NIB_W-1:0]   rxdNext;

  // One-group lookahead: the held group is decided while the next one is on rxCode.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCode    <= CG_IDLE;
      tailCntReg  <= '0;
      tailBitsReg <= '0;
    end else begin
      holdCode <= rxCode;
      if (rxCode == CG_T) begin
        tailCntReg  <= tailCount;
        tailBitsReg <= tailBits;
      end
    end
  end

  assign {holdValid, holdNib} = decodeGroup(holdCode);

  // Positions at or above the dribble count are padded with ones.
  for (genvar b = 0; b < NIB_W; b++) begin : g_pad
    assign tailNib[b] = (tailCntReg > TAIL_W'(b)) ? tailBitsReg[b] : 1'b1;
  end

  assign flags = '{
    holdJ:    (holdCode == CG_J),
    lookK:    (rxCode == CG_K),
    holdT:    (holdCode == CG_T),
    lookR:    (rxCode == CG_R),
    holdData: holdValid,
    holdIdle: (holdCode == CG_IDLE),
    tailPend: (tailCntReg != '0)
  };

  always_comb begin
    unique case (stb.sel)
      SEL_PRE:  rxdNext = PRE_NIB;
      SEL_DATA: rxdNext = holdNib;
      SEL_TAIL: rxdNext = tailNib;
      SEL_FC:   rxdNext = FC_NIB;
      default:  rxdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxDv <= 1'b0;
      rxEr <= 1'b0;
      rxd  <= '0;
    end else begin
      rxDv <= stb.dv;
      rxEr <= stb.er;
      rxd  <= rxdNext;
    end
  end

  AST_PRE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDv) |-> (rxd == PRE_NIB)) else $error("frame did not open with preamble"); // R1

  AST_FC_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (rxEr && !rxDv) |-> (rxd == FC_NIB)) else $error("false carrier code wrong"); // R9

  AST_CLEAN_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxDv) |-> (!rxEr && rxd == '0)) else $error("frame end not clean"); // R3

endmodule

// File: rtl/pcs_rx_decoder.sv
module pcs_rx_decoder
  import pcsrx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  rxCode,
  input  logic [2:0]  tailCount,
  input  logic [3:0]  tailBits,
  output logic        rxDv,
  output logic [3:0]  rxd,
  output logic        rxEr
);

  strobe_t  ctrlStb;
  flags_t   dpFlags;
  rxState_t ctrlState;

  pcsrx_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .flags (dpFlags),
    .stb   (ctrlStb),
    .state (ctrlState)
  );

  pcsrx_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxCode    (rxCode),
    .tailCount (tailCount),
    .tailBits  (tailBits),
    .stb       (ctrlStb),
    .flags     (dpFlags),
    .rxDv      (rxDv),
    .rxd       (rxd),
    .rxEr      (rxEr)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_IDLE && dpFlags.holdIdle) |=> (!rxDv && !rxEr && rxd == '0))
    else $error("idle outside frame not quiet"); // R10

endmodule

// File: tb/pcs_rx_decoder_test.sv
module pcs_rx_decoder_test;

  localparam int MAXN = 2048;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] rxCode = 5'b11111;
  logic [2:0] tailCount = '0;
  logic [3:0] tailBits = '0;
  logic       rxDv;
  logic [3:0] rxd;
  logic       rxEr;

  pcs_rx_decoder uut (
    .clk(clk), .rstN(rstN), .rxCode(rxCode), .tailCount(tailCount),
    .tailBits(tailBits), .rxDv(rxDv), .rxd(rxd), .rxEr(rxEr)
  );

  always #5 clk = ~clk;

  logic [4:0] codeArr [MAXN];
  logic [2:0] tcArr   [MAXN];
  logic [3:0] tbArr   [MAXN];
  logic       eDv     [MAXN];
  logic       eEr     [MAXN];
  logic [3:0] eRxd    [MAXN];
  string      tagArr  [MAXN];
  int n = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  localparam logic [4:0] I_ = 5'b11111, J_ = 5'b11000, K_ = 5'b10001;
  localparam logic [4:0] T_ = 5'b01101, R_ = 5'b00111, H_ = 5'b00100;

  function automatic logic [4:0] enc(input logic [3:0] v);
    case (v)
      4'h0: return 5'b11110; 4'h1: return 5'b01001; 4'h2: return 5'b10100; 4'h3: return 5'b10101;
      4'h4: return 5'b01010; 4'h5: return 5'b01011; 4'h6: return 5'b01110; 4'h7: return 5'b01111;
      4'h8: return 5'b10010; 4'h9: return 5'b10011; 4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011; 4'hE: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  task automatic put(input logic [4:0] c, input logic [2:0] tc, input logic [3:0] tb,
                     input logic dv, input logic er, input logic [3:0] d, input string tag);
    codeArr[n] = c; tcArr[n] = tc; tbArr[n] = tb;
    eDv[n] = dv; eEr[n] = er; eRxd[n] = d; tagArr[n] = tag;
    n++;
  endtask

  task automatic sof();
    put(I_, 0, 0, 0, 0, 4'h0, "R4");
    put(J_, 0, 0, 1, 0, 4'b0101, "R1");
    put(K_, 0, 0, 1, 0, 4'b0101, "R1");
  endtask

  task automatic cmp(input logic dv, input logic er, input logic [3:0] d,
                     input logic xdv, input logic xer, input logic [3:0] xd, input string tag);
    checks++;
    if (dv !== xdv || er !== xer || d !== xd) begin
      fails++;
      $display("FAIL %s: got dv=%b er=%b rxd=%h expected dv=%b er=%b rxd=%h",
               tag, dv, er, d, xdv, xer, xd);
    end
  endtask

  initial begin
    // quiet line
    for (int i = 0; i < 3; i++) put(I_, 0, 0, 0, 0, 4'h0, "R10");
    // full data sweep in one frame
    sof();
    for (int v = 0; v < 16; v++) put(enc(4'(v)), 0, 0, 1, 0, 4'(v), "R2");
    put(T_, 0, 0, 0, 0, 4'h0, "R3");
    put(R_, 0, 0, 0, 0, 4'h0, "R3");
    put(I_, 0, 0, 0, 0, 4'h0, "R10");
    // false carriers: J then idle, J then J then K
    put(J_, 0, 0, 0, 1, 4'b1110, "R9");
    put(I_, 0, 0, 0, 0, 4'h0, "R10");
    put(J_, 0, 0, 0, 1, 4'b1110, "R9");
    put(J_, 0, 0, 1, 0, 4'b0101, "R1");
    put(K_, 0, 0, 1, 0, 4'b0101, "R1");
    put(enc(4'h9), 0, 0, 1, 0, 4'h9, "R2");
    put(T_, 0, 0, 0, 0, 4'h0, "R3");
    put(R_, 0, 0, 0, 0, 4'h0, "R3");
    // dribble sweep over every count and bit pattern
    for (int tc = 1; tc < 8; tc++) begin
      for (int tb = 0; tb < 16; tb++) begin
        logic [3:0] xn;
        xn = (tc <= 4) ? (4'(tb) | 4'((4'hF << tc) & 4'hF)) : 4'(tb);
        sof();
        put(enc(4'(tb + tc)), 0, 0, 1, 0, 4'(tb + tc), "R2");
        put(T_, 3'(tc), 4'(tb), 1, 0, xn, (tc <= 4) ? "R5" : "R6");
        put(R_, 0, 0, 0, 0, 4'h0, (tc <= 4) ? "R5" : "R6");
      end
    end
    // error groups inside a frame
    sof();
    put(enc(4'h5), 0, 0, 1, 0, 4'h5, "R2");
    put(H_, 0, 0, 1, 1, 4'h0, "R7");
    put(enc(4'h6), 0, 0, 1, 0, 4'h6, "R7");
    put(5'b00000, 0, 0, 1, 1, 4'h0, "R8");
    put(K_, 0, 0, 1, 1, 4'h0, "R8");
    put(I_, 0, 0, 1, 1, 4'h0, "R8");
    put(T_, 0, 0, 1, 1, 4'h0, "R11");
    put(enc(4'h7), 0, 0, 1, 0, 4'h7, "R11");
    put(T_, 0, 0, 0, 0, 4'h0, "R3");
    put(R_, 0, 0, 0, 0, 4'h0, "R3");
    // back-to-back frame straight after R
    put(J_, 0, 0, 1, 0, 4'b0101, "R1");
    put(K_, 0, 0, 1, 0, 4'b0101, "R1");
    put(enc(4'hC), 0, 0, 1, 0, 4'hC, "R2");
    put(T_, 0, 0, 0, 0, 4'h0, "R3");
    put(R_, 0, 0, 0, 0, 4'h0, "R3");
    put(I_, 0, 0, 0, 0, 4'h0, "R10");

    // reset state
    repeat (3) @(negedge clk);
    cmp(rxDv, rxEr, rxd, 0, 0, 4'h0, "R12");
    rstN = 1'b1;
    for (int j = 0; j < n + 2; j++) begin
      @(negedge clk);
      if (j >= 2) cmp(rxDv, rxEr, rxd, eDv[j-2], eEr[j-2], eRxd[j-2], tagArr[j-2]);
      if (j < n) begin
        rxCode = codeArr[j]; tailCount = tcArr[j]; tailBits = tbArr[j];
      end else begin
        rxCode = I_; tailCount = '0; tailBits = '0;
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule